// File: doc/BRIEF.md
# Two-Channel Converter Data Staging and Transfer Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. Software writes 32-bit words into one of several data registers. Each register places the sample in its own way: 12 bits right-aligned, 12 bits left-aligned, or 8 bits with the low nibble zero-filled. Some registers serve one channel and some serve both channels with a single write. The block repacks each write into a 12-bit staging value per channel.

A per-channel transfer sequencer then copies the staging value into a 12-bit output register that drives the converter. The copy can happen without any trigger, on a software trigger bit, or three clocks after a rising edge on one of seven hardware event inputs. Each copy raises a one-cycle load strobe. The output registers can be read over the bus but never written.

Each channel's sequencer has five states:

- `ST_IDLE`: no transfer is pending.
- `ST_FIRE_DIR`: an untriggered copy is due at the next edge.
- `ST_FIRE_SW`: a software-triggered copy is due at the next edge.
- `ST_ARM`: waits after a hardware edge. It is held for `HW_LAT-1` cycles by a down-counter.
- `ST_FIRE_HW`: the hardware copy is due at the next edge.

The transitions are as follows.

- From `ST_IDLE`, `ST_FIRE_DIR` or `ST_FIRE_SW`, the *launch* decision picks the next state:
  - `ST_FIRE_DIR` on a data write while triggering is off.
  - `ST_FIRE_SW` on a pending or new software request while code 7 is selected.
  - `ST_ARM` on a rising edge of the selected hardware source.
  - `ST_IDLE` otherwise.
- `ST_ARM` moves to `ST_FIRE_HW` when its counter reaches 1.
- `ST_FIRE_HW` always returns to `ST_IDLE`. Hardware edges seen in `ST_ARM` or `ST_FIRE_HW` are dropped.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset, both output registers, both load strobes and every readable register are zero.
- R2: Single-channel data registers, by word index (channel A: 2, 3, 4; channel B: 5, 6, 7):
  - Index 2 or 5 stores write bits [11:0].
  - Index 3 or 6 stores write bits [15:4].
  - Index 4 or 7 stores bits [7:0] into staging bits [11:4] with [3:0] cleared.
  - A read of each returns the staging value in that same placement, and all other bits read as zero.
- R3: Dual data registers load both channels from one write:
  - Index 8: A from [11:0], B from [27:16].
  - Index 9: A from [15:4], B from [31:20].
  - Index 10: A from [7:0] and B from [15:8], each placed in staging bits [11:4].
  - A read returns the same packing.
- R4: With trigger-enable clear, the output register takes the staging value on the clock edge after the write edge, and the load strobe is high for that one cycle.
- R5: With trigger-enable set and select code 0 to 5 (event input `tmr_evt[code]`) or 6 (`ext_evt`), the output is loaded on the third clock edge after the edge that first samples the selected input high.
- R6: Only a rising edge triggers. A source held high causes no further load, and a source other than the selected one causes no load.
- R7: A rising edge on the selected source while a hardware transfer is pending (within the two edges after the triggering one) is ignored.
- R8: Software trigger:
  - With trigger-enable set and select code 7, writing 1 to the channel's bit of the software trigger register (word 1, A bit 0, B bit 1) loads the output on the next edge.
  - The bit reads back as 1 until that load and as 0 afterwards.
- R9: Output registers are read at word 11 (A) and 12 (B) in bits [11:0]. Writes to those words change nothing.
- R10: Control register, word 0:
  - Channel A: bit 0 enable, bit 1 trigger-enable, bits [4:2] select.
  - Channel B: the same fields at bits 8, 9 and [12:10].
  - A write leaves the select field unchanged when the channel's enable bit is already set.
- R11: Reserved control and trigger bits, and word 13, read as zero.
- R12: With trigger-enable set, writing a data register does not change the output until a trigger arrives.
- R13: When both channels select the same hardware source, one edge loads both outputs on the same clock edge with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_widx | input | 4 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| tmr_evt | input | 6 | Timer event inputs, select codes 0 to 5 |
| ext_evt | input | 1 | External event line, select code 6 |
| dac_out_a | output | 12 | Channel A output register |
| dac_out_b | output | 12 | Channel B output register |
| load_stb | output | 2 | Per-channel load strobe (bit 0 = A) |

## Verification
The outputs are due at different delays:

- An untriggered write shows on the outputs one edge after the write edge.
- A software trigger write shows one edge after the write edge.
- A hardware edge shows on the third edge after the edge that first samples the event high.

The bench drives every stimulus half a cycle before an edge and samples at each falling edge in between. At every intermediate sample it confirms that the output still holds its old value, so a load one cycle early or late is caught as a miscompare. Ignored edges and writes are followed by a window of several edges, long enough for any wrongly started transfer to land, and the output is checked against the value held before them.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;

    localparam int DW      = 12;
    localparam int SEL_W   = 3;
    localparam int SW_CODE = (1 << SEL_W) - 1;

    localparam logic [3:0] IDX_CTRL  = 4'd0;
    localparam logic [3:0] IDX_SWT   = 4'd1;
    localparam logic [3:0] IDX_A_R12 = 4'd2;
    localparam logic [3:0] IDX_D_R12 = 4'd8;
    localparam logic [3:0] IDX_D_L12 = 4'd9;
    localparam logic [3:0] IDX_D_R8  = 4'd10;
    localparam logic [3:0] IDX_OUT_A = 4'd11;
    localparam logic [3:0] IDX_OUT_B = 4'd12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_FIRE_HW,
        ST_FIRE_DIR,
        ST_FIRE_SW
    } xfer_state_e;

    typedef enum logic [1:0] {
        FMT_R12 = 2'd0,
        FMT_L12 = 2'd1,
        FMT_R8  = 2'd2
    } fmt_e;

    function automatic logic [DW-1:0] unpack_fld(fmt_e f, logic [15:0] w);
        case (f)
            FMT_R12: return w[11:0];
            FMT_L12: return w[15:4];
            default: return {w[7:0], 4'h0};
        endcase
    endfunction

    function automatic logic [15:0] pack_fld(fmt_e f, logic [DW-1:0] h);
        case (f)
            FMT_R12: return {4'h0, h};
            FMT_L12: return {h, 4'h0};
            default: return {8'h00, h[11:4]};
        endcase
    endfunction

endpackage

// File: rtl/dac_trig_edge.sv
module dac_trig_edge #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    output logic [N_SRC-1:0] rise_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= evt_i[i];
        end
        assign rise_o[i] = evt_i[i] & ~prev_q;
    end
endmodule

// File: rtl/dac_chan_seq.sv
module dac_chan_seq
    import dac_xfer_pkg::*;
#(
    parameter int HW_LAT = 3,
    parameter int N_HW   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_en_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [N_HW-1:0]   rise_i,
    input  logic              hold_wr_i,
    input  logic              sw_set_i,
    input  logic              sw_bit_i,
    input  logic [DW-1:0]     hold_i,
    output logic [DW-1:0]     out_o,
    output logic              stb_o,
    output logic              sw_clr_o
);
    localparam int N_CODE = 1 << SEL_W;
    localparam int CNT_W  = (HW_LAT > 2) ? $clog2(HW_LAT) : 1;

    xfer_state_e      state_q, state_d, launch;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [N_CODE-1:0] rise_pad;
    logic             hw_hit, sw_req, fire;
    logic [DW-1:0]    out_q;
    logic             stb_q;

    assign rise_pad = N_CODE'(rise_i);
    assign hw_hit   = rise_pad[sel_i];

    always_comb begin
        sw_req = sw_set_i | (sw_bit_i & (state_q != ST_FIRE_SW));
        if (!trig_en_i)
            launch = hold_wr_i ? ST_FIRE_DIR : ST_IDLE;
        else if (sel_i == SEL_W'(SW_CODE))
            launch = sw_req ? ST_FIRE_SW : ST_IDLE;
        else
            launch = hw_hit ? ST_ARM : ST_IDLE;

        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_FIRE_DIR, ST_FIRE_SW: begin
                state_d = launch;
                if (launch == ST_ARM) cnt_d = CNT_W'(HW_LAT - 1);
            end
            ST_ARM: begin
                if (cnt_q == CNT_W'(1)) state_d = ST_FIRE_HW;
                else                    cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_FIRE_HW: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign fire = (state_q == ST_FIRE_HW) || (state_q == ST_FIRE_DIR) ||
                  (state_q == ST_FIRE_SW);

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= fire;
            if (fire) out_q <= hold_i;
        end
    end

    assign out_o    = out_q;
    assign stb_o    = stb_q;
    assign sw_clr_o = (state_q == ST_FIRE_SW);

    assert_out_moves_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> stb_q);

    assert_hw_fire_after_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE_HW) |-> ($past(state_q) == ST_ARM));

    assert_hw_edge_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && trig_en_i && sel_i != SEL_W'(SW_CODE) && hw_hit)
        |=> (state_q == ST_ARM));

    assert_pending_edge_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE_HW) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
    import dac_xfer_pkg::*;
#(
    parameter int HW_LAT = 3,
    parameter int N_TMR  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [3:0]    bus_widx,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [N_TMR-1:0] tmr_evt,
    input  logic          ext_evt,
    output logic [DW-1:0] dac_out_a,
    output logic [DW-1:0] dac_out_b,
    output logic [1:0]    load_stb
);
    localparam int N_CH  = 2;
    localparam int N_HW  = N_TMR + 1;
    localparam int CH_SP = 8;

    logic [N_HW-1:0]  rise;
    logic [DW-1:0]    hold_q [N_CH];
    logic [DW-1:0]    hold_d [N_CH];
    logic [DW-1:0]    out_arr [N_CH];
    logic [N_CH-1:0]  hold_wr, en_q, ten_q, sw_q, sw_set, sw_clr;
    logic [SEL_W-1:0] sel_q [N_CH];
    logic             wr_ctrl, wr_swt;

    dac_trig_edge #(.N_SRC(N_HW)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt_i({ext_evt, tmr_evt}), .rise_o(rise)
    );

    assign wr_ctrl = bus_we && (bus_widx == IDX_CTRL);
    assign wr_swt  = bus_we && (bus_widx == IDX_SWT);

    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            hold_wr[c] = 1'b0;
            hold_d[c]  = hold_q[c];
            sw_set[c]  = wr_swt && bus_wdata[c];
            for (int f = 0; f < 3; f++) begin
                if (bus_we && bus_widx == 4'(int'(IDX_A_R12) + 3*c + f)) begin
                    hold_wr[c] = 1'b1;
                    hold_d[c]  = unpack_fld(fmt_e'(2'(f)), bus_wdata[15:0]);
                end
            end
        end
        if (bus_we) begin
            if (bus_widx == IDX_D_R12 || bus_widx == IDX_D_L12) begin
                hold_wr = '1;
                hold_d[0] = unpack_fld(fmt_e'(2'(bus_widx - IDX_D_R12)), bus_wdata[15:0]);
                hold_d[1] = unpack_fld(fmt_e'(2'(bus_widx - IDX_D_R12)), bus_wdata[31:16]);
            end else if (bus_widx == IDX_D_R8) begin
                hold_wr = '1;
                hold_d[0] = unpack_fld(FMT_R8, {8'h00, bus_wdata[7:0]});
                hold_d[1] = unpack_fld(FMT_R8, {8'h00, bus_wdata[15:8]});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) begin
                hold_q[c] <= '0;
                sel_q[c]  <= '0;
            end
            en_q  <= '0;
            ten_q <= '0;
            sw_q  <= '0;
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                hold_q[c] <= hold_d[c];
                if (wr_ctrl) begin
                    en_q[c]  <= bus_wdata[CH_SP*c];
                    ten_q[c] <= bus_wdata[CH_SP*c + 1];
                    if (!en_q[c]) sel_q[c] <= bus_wdata[CH_SP*c + 2 +: SEL_W];
                end
                if (wr_swt)         sw_q[c] <= bus_wdata[c];
                else if (sw_clr[c]) sw_q[c] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dac_chan_seq #(.HW_LAT(HW_LAT), .N_HW(N_HW)) u_seq (
            .clk(clk), .rst_n(rst_n),
            .trig_en_i(ten_q[g]), .sel_i(sel_q[g]), .rise_i(rise),
            .hold_wr_i(hold_wr[g]), .sw_set_i(sw_set[g]), .sw_bit_i(sw_q[g]),
            .hold_i(hold_q[g]), .out_o(out_arr[g]), .stb_o(load_stb[g]),
            .sw_clr_o(sw_clr[g])
        );

        assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            en_q[g] |=> $stable(sel_q[g]));

        assert_sw_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[g] && !wr_swt) |=> !sw_q[g]);
    end

    assign dac_out_a = out_arr[0];
    assign dac_out_b = out_arr[1];

    always_comb begin
        bus_rdata = '0;
        case (bus_widx)
            IDX_CTRL: for (int c = 0; c < N_CH; c++)
                bus_rdata[CH_SP*c +: 5] = {sel_q[c], ten_q[c], en_q[c]};
            IDX_SWT:   bus_rdata[N_CH-1:0] = sw_q;
            4'd2, 4'd3, 4'd4:
                bus_rdata[15:0] = pack_fld(fmt_e'(2'(bus_widx - 4'd2)), hold_q[0]);
            4'd5, 4'd6, 4'd7:
                bus_rdata[15:0] = pack_fld(fmt_e'(2'(bus_widx - 4'd5)), hold_q[1]);
            IDX_D_R12, IDX_D_L12:
                bus_rdata = {pack_fld(fmt_e'(2'(bus_widx - IDX_D_R12)), hold_q[1]),
                             pack_fld(fmt_e'(2'(bus_widx - IDX_D_R12)), hold_q[0])};
            IDX_D_R8:  bus_rdata[15:0] = {hold_q[1][11:4], hold_q[0][11:4]};
            IDX_OUT_A: bus_rdata[DW-1:0] = out_arr[0];
            IDX_OUT_B: bus_rdata[DW-1:0] = out_arr[1];
            default:   bus_rdata = '0;
        endcase
    end

    assert_ctrl_rsv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_widx == IDX_CTRL) |-> (bus_rdata[31:13] == '0 && bus_rdata[7:5] == '0));

    assert_out_read_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_widx == IDX_OUT_A) |-> (bus_rdata == {20'h0, dac_out_a}));
endmodule

// File: tb/dac_xfer_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_xfer_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  tmr_evt = '0;
    logic        ext_evt = 1'b0;
    logic [11:0] dac_out_a, dac_out_b;
    logic [1:0]  load_stb;

    int n_vec = 0;
    int n_bad = 0;
    logic [11:0] exp_out [2];

    always #2 clk = ~clk;

    dac_xfer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_widx(bus_widx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_evt(tmr_evt),
        .ext_evt(ext_evt), .dac_out_a(dac_out_a), .dac_out_b(dac_out_b),
        .load_stb(load_stb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_widx = idx; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        bus_widx = idx;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic set_src(input int s, input logic v);
        if (s < 6) tmr_evt[s] = v;
        else       ext_evt = v;
    endtask

    function automatic logic [11:0] cur_out(input int c);
        return (c == 0) ? dac_out_a : dac_out_b;
    endfunction

    task automatic chk_outs(input string tag, input logic [1:0] stb);
        chk({tag, " out A"}, {20'h0, dac_out_a}, {20'h0, exp_out[0]});
        chk({tag, " out B"}, {20'h0, dac_out_b}, {20'h0, exp_out[1]});
        chk({tag, " strobe"}, {30'h0, load_stb}, {30'h0, stb});
    endtask

    function automatic logic [11:0] exp_unpack(input int f, input logic [15:0] w);
        if (f == 0)      return w[11:0];
        else if (f == 1) return w[15:4];
        else             return {w[7:0], 4'h0};
    endfunction

    function automatic logic [31:0] exp_pack(input int f, input logic [11:0] h);
        if (f == 0)      return {20'h0, h};
        else if (f == 1) return {16'h0, h, 4'h0};
        else             return {24'h0, h[11:4]};
    endfunction

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        exp_out[0] = '0; exp_out[1] = '0;
        repeat (3) tick();
        // R1: reset state
        chk_outs("R1 reset", 2'b00);
        for (int i = 0; i < 14; i++) begin
            rd(4'(i), r);
            chk("R1 register reset", r, 32'h0);
        end
        rst_n = 1'b1;
        tick();

        // R2 / R4: single-channel formats, untriggered
        for (int c = 0; c < 2; c++) begin
            for (int f = 0; f < 3; f++) begin
                for (int i = 0; i < 6; i++) begin
                    logic [31:0] w;
                    w = 32'(i) * 32'h9E37_79B9 + 32'(c * 977 + f * 131 + 5);
                    wr(4'(2 + 3*c + f), w);
                    chk_outs("R4 not before one edge", 2'b00);
                    exp_out[c] = exp_unpack(f, w[15:0]);
                    tick();
                    chk_outs("R4 untriggered load", c == 0 ? 2'b01 : 2'b10);
                    rd(4'(2 + 3*c + f), r);
                    chk("R2 staging readback", r, exp_pack(f, exp_out[c]));
                    tick();
                    chk_outs("R4 strobe one cycle", 2'b00);
                end
            end
        end

        // R3: dual formats, untriggered
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < 5; i++) begin
                logic [31:0] w;
                w = 32'(i + 1) * 32'h7F4A_7C15 + 32'(f * 4099);
                wr(4'(8 + f), w);
                chk_outs("R3 not before one edge", 2'b00);
                if (f == 0)      begin exp_out[0] = w[11:0];  exp_out[1] = w[27:16]; end
                else if (f == 1) begin exp_out[0] = w[15:4];  exp_out[1] = w[31:20]; end
                else             begin exp_out[0] = {w[7:0], 4'h0}; exp_out[1] = {w[15:8], 4'h0}; end
                tick();
                chk_outs("R3 dual load", 2'b11);
                rd(4'(8 + f), r);
                if (f == 0)      chk("R3 dual readback", r, {4'h0, exp_out[1], 4'h0, exp_out[0]});
                else if (f == 1) chk("R3 dual readback", r, {exp_out[1], 4'h0, exp_out[0], 4'h0});
                else             chk("R3 dual readback", r, {16'h0, exp_out[1][11:4], exp_out[0][11:4]});
                tick();
            end
        end

        // R5 / R6 / R12: sweep every hardware source on both channels
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 7; s++) begin
                logic [11:0] v;
                int other;
                other = (s + 1) % 7;
                wr(4'd0, 32'(((s << 2) | 2) << (8*c)));
                v = 12'(s * 613 + c * 1777 + 341);
                wr(4'(2 + 3*c), {20'h0, v});
                repeat (3) begin
                    tick();
                    chk_outs("R12 no load while triggered", 2'b00);
                end
                set_src(other, 1'b1);
                repeat (5) tick();
                chk_outs("R6 unselected source ignored", 2'b00);
                set_src(other, 1'b0);
                set_src(s, 1'b1);
                tick();
                chk_outs("R5 edge+1", 2'b00);
                tick();
                chk_outs("R5 edge+2", 2'b00);
                tick();
                chk_outs("R5 edge+3 early check", 2'b00);
                exp_out[c] = v;
                tick();
                chk_outs("R5 hardware load", c == 0 ? 2'b01 : 2'b10);
                wr(4'(2 + 3*c), {20'h0, ~v});
                repeat (4) tick();
                chk_outs("R6 held level no reload", 2'b00);
                set_src(s, 1'b0);
                tick();
            end
        end

        // R7: second edge while pending is dropped
        begin
            logic [11:0] v;
            v = 12'h5C3;
            wr(4'd0, 32'h0000_0002);
            wr(4'd2, {20'h0, v});
            set_src(0, 1'b1); tick();
            set_src(0, 1'b0); tick();
            set_src(0, 1'b1); tick();
            set_src(0, 1'b0);
            exp_out[0] = v;
            tick();
            chk_outs("R7 first transfer", 2'b01);
            wr(4'd2, 32'h0000_0A3E);
            for (int i = 0; i < 5; i++) begin
                tick();
                chk_outs("R7 pending edge ignored", 2'b00);
            end
        end

        // R8: software trigger on both channels, then one channel
        wr(4'd0, 32'h0000_1E1E);
        wr(4'd8, 32'h0777_0888);
        repeat (2) tick();
        chk_outs("R8 no load before soft trigger", 2'b00);
        wr(4'd1, 32'h0000_0003);
        rd(4'd1, r);
        chk("R8 soft bits pending", r, 32'h3);
        chk_outs("R8 not before one edge", 2'b00);
        exp_out[0] = 12'h888; exp_out[1] = 12'h777;
        tick();
        chk_outs("R8 soft load both", 2'b11);
        rd(4'd1, r);
        chk("R8 soft bits cleared", r, 32'h0);
        wr(4'd5, 32'h0000_0123);
        wr(4'd1, 32'h0000_0002);
        exp_out[1] = 12'h123;
        tick();
        chk_outs("R8 soft load channel B", 2'b10);
        tick();
        chk_outs("R8 no repeat", 2'b00);

        // R9: output registers are read-only
        wr(4'd11, 32'hFFFF_FFFF);
        wr(4'd12, 32'h0000_0000);
        repeat (2) tick();
        chk_outs("R9 output write ignored", 2'b00);
        rd(4'd11, r);
        chk("R9 read out A", r, {20'h0, exp_out[0]});
        rd(4'd12, r);
        chk("R9 read out B", r, {20'h0, exp_out[1]});

        // R10: select locked while enabled
        wr(4'd0, 32'h0000_000D);
        rd(4'd0, r); chk("R10 enable with select 3", r, 32'h0000_000D);
        wr(4'd0, 32'h0000_0015);
        rd(4'd0, r); chk("R10 select locked", r, 32'h0000_000D);
        wr(4'd0, 32'h0000_0014);
        rd(4'd0, r); chk("R10 locked on disabling write", r, 32'h0000_000C);
        wr(4'd0, 32'h0000_0014);
        rd(4'd0, r); chk("R10 select free when disabled", r, 32'h0000_0014);

        // R11: reserved bits
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, r); chk("R11 control reserved zero", r, 32'h0000_1F1F);
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, r); chk("R11 R10 lock both channels", r, 32'h0000_1C1C);
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, r); chk("R11 control cleared", r, 32'h0);
        wr(4'd1, 32'hFFFF_FFFC);
        rd(4'd1, r); chk("R11 soft register reserved zero", r, 32'h0);
        rd(4'd13, r); chk("R11 spare word zero", r, 32'h0);
        tick();
        exp_out[0] = dac_out_a; exp_out[1] = dac_out_b;

        // R13: shared hardware source loads both together
        wr(4'd0, 32'h0000_0A0A);
        wr(4'd9, 32'hABC0_DEF0);
        set_src(2, 1'b1);
        repeat (3) begin
            tick();
            chk_outs("R13 before third edge", 2'b00);
        end
        exp_out[0] = 12'hDEF; exp_out[1] = 12'hABC;
        tick();
        chk_outs("R13 simultaneous load", 2'b11);
        set_src(2, 1'b0);
        tick();
        chk_outs("R13 single strobe", 2'b00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule